// File: doc/BRIEF.md
# Memory Access Concurrency Cycle Monitor

This block is a performance monitor attached to a single tier of a memory hierarchy. It keeps two running totals: how many accesses were requested at that tier, and how many clock cycles the tier spent busy with at least one access in flight. Software reads both totals and divides the first by the second to get an accesses-per-cycle figure. Overlapping accesses share the cycle counter: a cycle with ten accesses in flight adds the same single count as a cycle with one.

The tier is considered busy when any of three detectors fires. The first is the request-valid vector of the processor/cache command interface. The second is the per-stage valid vector of the cache access pipeline. The third is a single not-empty flag from the miss-status holding register table. A second operating mode serves the main-memory tier instead. In that mode, accesses come from a DRAM access strobe and busy cycles come from the last-level-cache miss-holding not-empty flag.

Counting runs only while enabled. A synchronous clear resets the totals. A snapshot pulse copies both totals into hold registers on the same edge, so a ratio taken from the snapshots is self-consistent. Both counters saturate rather than wrap, and a sticky flag records saturation.

Top module: `acc_cycle_monitor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both counters, both snapshot registers and `sat_flag` read zero.
- R2: In level mode (`mem_mode`=0) with `enable` high, `busy_cycles` rises by exactly one on each edge whose cycle had any activity, however many requests, pipeline stages and outstanding misses overlap in that cycle.
- R3: In level mode, each detector alone makes a cycle active: any single bit of `req_vld`, any single bit of `pipe_vld`, or `mshr_nonempty`. A cycle with none of them leaves `busy_cycles` unchanged.
- R4: In level mode, `access_count` rises on each enabled edge by the number of set bits in `req_vld`.
- R5: In main-memory mode (`mem_mode`=1), `access_count` rises by one when `dram_access` is high. `busy_cycles` rises by one when `llc_mshr_nonempty` is high. `req_vld`, `pipe_vld` and `mshr_nonempty` have no effect in this mode.
- R6: With `enable` low, neither counter changes, whatever the detector inputs.
- R7: `clear` zeroes both counters and `sat_flag` on the next edge. It wins over counting in the same cycle.
- R8: Each counter stops at all-ones and never wraps. An increment that would pass all-ones leaves the counter at all-ones.
- R9: `sat_flag` goes high on the edge at which either counter reaches all-ones. It stays high until `clear`.
- R10: A `snapshot` pulse loads `snap_access` and `snap_cycles` on the same edge with the counter values held just before that edge. Without a pulse, both snapshot registers hold their values, even across `clear`.
- R11: Counter outputs are registered. Activity in a cycle shows up at the outputs only after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counting allowed when high |
| clear | input | 1 | Synchronous zero of counters and saturation flag |
| snapshot | input | 1 | One-cycle pulse copying both counters to the hold registers |
| mem_mode | input | 1 | 0 = level mode, 1 = main-memory mode |
| req_vld | input | REQ_W | Request strobes on the processor/cache command interface |
| pipe_vld | input | STAGES | One valid bit per cache access pipeline stage |
| mshr_nonempty | input | 1 | Miss-holding table of this level holds an entry |
| dram_access | input | 1 | One DRAM access issued this cycle |
| llc_mshr_nonempty | input | 1 | Last-level-cache miss-holding table holds an entry |
| access_count | output | CNT_W | Running access total |
| busy_cycles | output | CNT_W | Running busy-cycle total |
| snap_access | output | CNT_W | Captured access total |
| snap_cycles | output | CNT_W | Captured busy-cycle total |
| sat_flag | output | 1 | Sticky: a counter has reached all-ones |

## Verification
The assertions assume `clear` and `snapshot` are sampled synchronously and that `rst` is held from time zero. They also assume the increment width can never exceed the counter width, which holds whenever `REQ_W` is below 2^`CNT_W`. The stimulus changes every input only on falling edges, holding each value across one full rising edge. It shrinks the counters to 8 bits so that saturation is reached within a few dozen cycles, and it clears before each scenario so every expected total starts from a known zero.

// File: rtl/acm_pkg.sv
package acm_pkg;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_DRAM  = 1'b1
  } acm_mode_e;

  // Bits needed to hold a value in 0..n
  function automatic int unsigned acm_count_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/acm_activity.sv
module acm_activity
  import acm_pkg::*;
#(
  parameter int unsigned REQ_W  = 4,
  parameter int unsigned STAGES = 4,
  parameter int unsigned INC_W  = 3
) (
  input  acm_mode_e          mode,
  input  logic [REQ_W-1:0]   req_vld,
  input  logic [STAGES-1:0]  pipe_vld,
  input  logic               mshr_nonempty,
  input  logic               dram_access,
  input  logic               llc_mshr_nonempty,
  output logic [INC_W-1:0]   acc_inc,
  output logic               busy
);

  logic [INC_W-1:0] req_pop;
  logic             req_any;
  logic             pipe_any;

  // population count of the request strobes
  always_comb begin
    req_pop = '0;
    for (int i = 0; i < int'(REQ_W); i++) begin
      req_pop = req_pop + INC_W'(req_vld[i]);
    end
  end

  assign req_any = |req_vld;

  generate
    if (STAGES == 1) begin : g_pipe_single
      assign pipe_any = pipe_vld[0];
    end else begin : g_pipe_multi
      assign pipe_any = |pipe_vld;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_DRAM: begin
        acc_inc = INC_W'(dram_access);
        busy    = llc_mshr_nonempty;
      end
      default: begin
        acc_inc = req_pop;
        busy    = req_any | pipe_any | mshr_nonempty;
      end
    endcase
  end

endmodule

// File: rtl/acm_sat_counter.sv
module acm_sat_counter #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit_max
);

  localparam int unsigned PAD_W = CNT_W + 1 - INC_W;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;

  assign sum     = {1'b0, cnt_q} + {{PAD_W{1'b0}}, inc};
  assign nxt     = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  assign hit_max = en & ~clr & (&nxt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= nxt;
    end
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q >= $past(cnt_q));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0);

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(cnt_q));

endmodule

// File: rtl/acm_snap.sv
module acm_snap #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R10
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));

endmodule

// File: rtl/acc_cycle_monitor.sv
module acc_cycle_monitor
  import acm_pkg::*;
#(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned REQ_W  = 4,
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              clear,
  input  logic              snapshot,
  input  logic              mem_mode,
  input  logic [REQ_W-1:0]  req_vld,
  input  logic [STAGES-1:0] pipe_vld,
  input  logic              mshr_nonempty,
  input  logic              dram_access,
  input  logic              llc_mshr_nonempty,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  busy_cycles,
  output logic [CNT_W-1:0]  snap_access,
  output logic [CNT_W-1:0]  snap_cycles,
  output logic              sat_flag
);

  localparam int unsigned INC_W = acm_count_bits(REQ_W);

  logic [INC_W-1:0] acc_inc;
  logic             busy;
  logic             acc_hit;
  logic             cyc_hit;

  acm_activity #(
    .REQ_W (REQ_W),
    .STAGES(STAGES),
    .INC_W (INC_W)
  ) u_activity (
    .mode             (acm_mode_e'(mem_mode)),
    .req_vld          (req_vld),
    .pipe_vld         (pipe_vld),
    .mshr_nonempty    (mshr_nonempty),
    .dram_access      (dram_access),
    .llc_mshr_nonempty(llc_mshr_nonempty),
    .acc_inc          (acc_inc),
    .busy             (busy)
  );

  acm_sat_counter #(
    .CNT_W(CNT_W),
    .INC_W(INC_W)
  ) u_acc_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clear),
    .en     (enable),
    .inc    (acc_inc),
    .cnt_q  (access_count),
    .hit_max(acc_hit)
  );

  acm_sat_counter #(
    .CNT_W(CNT_W),
    .INC_W(1)
  ) u_cyc_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clear),
    .en     (enable),
    .inc    (busy),
    .cnt_q  (busy_cycles),
    .hit_max(cyc_hit)
  );

  acm_snap #(.W(CNT_W)) u_snap_acc (
    .clk (clk),
    .rst (rst),
    .load(snapshot),
    .d   (access_count),
    .q   (snap_access)
  );

  acm_snap #(.W(CNT_W)) u_snap_cyc (
    .clk (clk),
    .rst (rst),
    .load(snapshot),
    .d   (busy_cycles),
    .q   (snap_cycles)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sat_flag <= 1'b0;
    end else if (acc_hit || cyc_hit) begin
      sat_flag <= 1'b1;
    end
  end

  // R2
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (busy_cycles - $past(busy_cycles)) <= CNT_W'(1));

  // R4
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (access_count - $past(access_count)) <= CNT_W'(REQ_W));

  // R5
  dram_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_mode && !llc_mshr_nonempty && !clear) |=> $stable(busy_cycles));

  // R9
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !clear) |=> sat_flag);

  // R9
  sat_seen_chk: assert property (@(posedge clk) disable iff (rst)
    ((&access_count) || (&busy_cycles)) |-> sat_flag);

endmodule

// File: tb/acc_cycle_monitor_bench.sv
module acc_cycle_monitor_bench;

  localparam int unsigned CW = 8;
  localparam int unsigned RW = 4;
  localparam int unsigned SW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          enable, clear, snapshot, mem_mode;
  logic [RW-1:0] req_vld;
  logic [SW-1:0] pipe_vld;
  logic          mshr_nonempty, dram_access, llc_mshr_nonempty;
  logic [CW-1:0] access_count, busy_cycles, snap_access, snap_cycles;
  logic          sat_flag;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  acc_cycle_monitor #(
    .CNT_W (CW),
    .REQ_W (RW),
    .STAGES(SW)
  ) u_acc_cycle_monitor (
    .clk              (clk),
    .rst              (rst),
    .enable           (enable),
    .clear            (clear),
    .snapshot         (snapshot),
    .mem_mode         (mem_mode),
    .req_vld          (req_vld),
    .pipe_vld         (pipe_vld),
    .mshr_nonempty    (mshr_nonempty),
    .dram_access      (dram_access),
    .llc_mshr_nonempty(llc_mshr_nonempty),
    .access_count     (access_count),
    .busy_cycles      (busy_cycles),
    .snap_access      (snap_access),
    .snap_cycles      (snap_cycles),
    .sat_flag         (sat_flag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // set detector inputs, then let one rising edge pass
  task automatic cyc(input logic [RW-1:0] rq, input logic [SW-1:0] pv,
                     input logic ms, input logic dr, input logic lm);
    req_vld = rq; pipe_vld = pv; mshr_nonempty = ms;
    dram_access = dr; llc_mshr_nonempty = lm;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    req_vld = '0; pipe_vld = '0; mshr_nonempty = 0;
    dram_access = 0; llc_mshr_nonempty = 0;
  endtask

  task automatic do_clear();
    idle_inputs();
    clear = 1; @(negedge clk); clear = 0;
  endtask

  task automatic t_reset();
    chk("R1", "access_count", access_count, 0);
    chk("R1", "busy_cycles", busy_cycles, 0);
    chk("R1", "snap_access", snap_access, 0);
    chk("R1", "snap_cycles", snap_cycles, 0);
    chk("R1", "sat_flag", sat_flag, 0);
  endtask

  task automatic t_overlap();
    do_clear(); mem_mode = 0; enable = 1;
    req_vld = 4'b1111; pipe_vld = 3'b111; mshr_nonempty = 1;
    #1;
    chk("R11", "count before edge", access_count, 0);
    @(negedge clk);
    chk("R11", "access after edge", access_count, 4);
    chk("R2", "busy with full overlap", busy_cycles, 1);
    cyc(4'b0101, 3'b000, 0, 0, 0);
    chk("R4", "popcount two", access_count, 6);
    chk("R2", "busy second cycle", busy_cycles, 2);
    cyc(4'b1000, 3'b000, 0, 0, 0);
    chk("R4", "popcount one", access_count, 7);
  endtask

  task automatic t_sources();
    do_clear(); mem_mode = 0; enable = 1;
    cyc(4'b0000, 3'b100, 0, 0, 0);
    chk("R3", "pipe stage alone", busy_cycles, 1);
    chk("R4", "no requests", access_count, 0);
    cyc(4'b0000, 3'b000, 1, 0, 0);
    chk("R3", "mshr alone", busy_cycles, 2);
    cyc(4'b0010, 3'b000, 0, 0, 0);
    chk("R3", "one request alone", busy_cycles, 3);
    cyc(4'b0000, 3'b000, 0, 1, 1);
    chk("R3", "idle cycle", busy_cycles, 3);
    chk("R5", "dram strobe ignored in level mode", access_count, 1);
  endtask

  task automatic t_mem_mode();
    do_clear(); mem_mode = 1; enable = 1;
    cyc(4'b1111, 3'b111, 1, 0, 0);
    chk("R5", "level inputs ignored acc", access_count, 0);
    chk("R5", "level inputs ignored cyc", busy_cycles, 0);
    cyc(4'b0000, 3'b000, 0, 1, 0);
    chk("R5", "dram access counted", access_count, 1);
    chk("R5", "no llc busy", busy_cycles, 0);
    cyc(4'b0000, 3'b000, 0, 1, 1);
    chk("R5", "llc busy counted", busy_cycles, 1);
    chk("R5", "dram access again", access_count, 2);
    mem_mode = 0;
  endtask

  task automatic t_enable();
    do_clear(); mem_mode = 0; enable = 0;
    cyc(4'b1111, 3'b111, 1, 1, 1);
    chk("R6", "disabled acc", access_count, 0);
    chk("R6", "disabled cyc", busy_cycles, 0);
    enable = 1;
  endtask

  task automatic t_snap();
    do_clear(); mem_mode = 0; enable = 1;
    cyc(4'b0011, 3'b000, 0, 0, 0);
    cyc(4'b0011, 3'b000, 0, 0, 0);
    snapshot = 1;
    cyc(4'b1111, 3'b000, 0, 0, 0);
    snapshot = 0;
    chk("R10", "snap_access pre-edge", snap_access, 4);
    chk("R10", "snap_cycles pre-edge", snap_cycles, 2);
    chk("R10", "counter moved on", access_count, 8);
    cyc(4'b1111, 3'b000, 0, 0, 0);
    do_clear();
    chk("R10", "snap_access held", snap_access, 4);
    chk("R10", "snap_cycles held", snap_cycles, 2);
  endtask

  task automatic t_clear();
    mem_mode = 0; enable = 1;
    cyc(4'b0001, 3'b000, 0, 0, 0);
    clear = 1;
    cyc(4'b1111, 3'b111, 1, 0, 0);
    clear = 0;
    chk("R7", "clear beats count acc", access_count, 0);
    chk("R7", "clear beats count cyc", busy_cycles, 0);
  endtask

  task automatic t_sat();
    do_clear(); mem_mode = 0; enable = 1;
    for (int i = 0; i < 63; i++) cyc(4'b1111, 3'b000, 0, 0, 0);
    chk("R8", "just below max", access_count, 252);
    chk("R9", "flag low below max", sat_flag, 0);
    cyc(4'b1111, 3'b000, 0, 0, 0);
    chk("R8", "saturated", access_count, 255);
    chk("R9", "flag set", sat_flag, 1);
    chk("R2", "busy total", busy_cycles, 64);
    cyc(4'b1111, 3'b000, 0, 0, 0);
    chk("R8", "no wrap", access_count, 255);
    cyc(4'b0000, 3'b000, 0, 0, 0);
    chk("R9", "flag sticky", sat_flag, 1);
    do_clear();
    chk("R7", "clear drops flag", sat_flag, 0);
    chk("R7", "clear zeroes acc", access_count, 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; enable = 0; clear = 0; snapshot = 0; mem_mode = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_overlap();
    t_sources();
    t_mem_mode();
    t_enable();
    t_snap();
    t_clear();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule